// File: doc/BRIEF.md
# AGC Loop Filter with Mean and Median Settling

This block is the loop filter of a digital downconverter's automatic gain control. On every output sample it compares a signal-magnitude value with a programmable threshold to form a signed gain error. It scales that error by one of two programmable loop gains and adds the result to a saturating accumulator. The accumulator is the gain word sent to the data-path multiplier.

Each loop gain is a 4-bit mantissa (code/16) times a power of two set by a 4-bit exponent. Two gain sets are stored, and an external pin selects between them. Typically one set is a coarse gain for fast acquisition at the start of a burst and the other a fine gain for tracking.

Two settling modes are available:
- **Mean (proportional):** the error is used as is, so the loop settles asymptotically.
- **Median (fixed step):** only the sign of the error is kept, so the loop slews at a constant rate. The settling time then does not depend on the signal level.

A sync event always clears the accumulator. A backend reset clears it only when the hold option is off.

Top module: `agc_loop_filter`

## Requirements
- R1: The per-sample step is floor(m × err × 2^(e−23)), where m is the 4-bit mantissa code (0..15) and e the 4-bit exponent code (0..15). This is the gain m/16 × 2^(e−19) applied to err in accumulator LSBs. For example, m=5 and e=12 give 0.3125 × 2^-7.
- R2: `gsel_i`=0 uses `man0_i`/`exp0_i`; `gsel_i`=1 uses `man1_i`/`exp1_i`.
- R3: With `median_i`=0, err = `thr_i` − `mag_i`, taken as a signed 13-bit value.
- R4: With `median_i`=1, err is +1024 (13'b0010000000000) when `thr_i` ≥ `mag_i`, and −1024 (13'b1110000000000) otherwise. Zero error counts as positive.
- R5: A high `sync_clr_i` clears the accumulator to 0 at the next edge, whatever the other inputs are, and takes priority over an update.
- R6: A high `be_rst_i` clears the accumulator when `hold_i`=0. It leaves the accumulator unchanged when `hold_i`=1.
- R7: A zero mantissa in the selected set leaves the accumulator unchanged on a valid sample.
- R8: The accumulator saturates to [`lim_lo_i`, `lim_hi_i`] (signed) and never wraps.
- R9: The accumulator changes only on edges where `valid_i` is high or a clear applies. `gain_o` follows the accumulator one cycle later.
- R10: The change in the accumulator per valid sample is at most 240 LSBs in magnitude, with default widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Output-sample strobe |
| mag_i | input | 12 | Signal magnitude (unsigned) |
| thr_i | input | 12 | Magnitude threshold (unsigned) |
| median_i | input | 1 | 1 = fixed-step settling, 0 = proportional |
| gsel_i | input | 1 | Loop-gain set select |
| man0_i | input | 4 | Gain set 0 mantissa |
| exp0_i | input | 4 | Gain set 0 exponent |
| man1_i | input | 4 | Gain set 1 mantissa |
| exp1_i | input | 4 | Gain set 1 exponent |
| lim_hi_i | input | 20 | Upper gain limit (signed) |
| lim_lo_i | input | 20 | Lower gain limit (signed) |
| hold_i | input | 1 | 1 = backend reset keeps the accumulator |
| sync_clr_i | input | 1 | Sync event, always clears |
| be_rst_i | input | 1 | Backend reset |
| gain_o | output | 20 | Registered gain word (signed) |

## Verification
The limit and slew properties assume that `lim_lo_i` ≤ `lim_hi_i` and that the limits do not change across an update. The bench programs each limit pair once, before a run of samples, and always with lo below hi. The idle and pipeline properties need no input assumption beyond the reset starting asserted. The sweep covers every mantissa and exponent code in both gain sets and both modes, with full-scale positive, full-scale negative, zero and mid-range errors.

// File: rtl/agc_loop_filter.sv
module agc_loop_filter #(
  parameter int MAG_W = 12,
  parameter int ACC_W = 20,
  parameter int SHIFT_BASE = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid_i,
  input  logic [MAG_W-1:0]        mag_i,
  input  logic [MAG_W-1:0]        thr_i,
  input  logic                    median_i,
  input  logic                    gsel_i,
  input  logic [3:0]              man0_i,
  input  logic [3:0]              exp0_i,
  input  logic [3:0]              man1_i,
  input  logic [3:0]              exp1_i,
  input  logic signed [ACC_W-1:0] lim_hi_i,
  input  logic signed [ACC_W-1:0] lim_lo_i,
  input  logic                    hold_i,
  input  logic                    sync_clr_i,
  input  logic                    be_rst_i,
  output logic signed [ACC_W-1:0] gain_o
);
  localparam int ERR_W = MAG_W + 1;
  localparam int PRD_W = ERR_W + 5;
  localparam int SUM_W = ACC_W + 2;
  localparam int MAX_STEP = (15 << (ERR_W - 1)) >> (SHIFT_BASE - 15);
  localparam logic signed [ERR_W-1:0] FIX_POS = ERR_W'(1) << (ERR_W - 3);
  localparam logic signed [ERR_W-1:0] FIX_NEG = -FIX_POS;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ERR_W-1:0] raw_err, err;
  logic [3:0]              cur_man, cur_exp;
  logic [4:0]              sh;
  logic signed [PRD_W-1:0] prod;
  logic signed [SUM_W-1:0] step, sum, hi_x, lo_x;
  logic signed [ACC_W-1:0] nxt;
  logic                    clr_any;

  assign cur_man = gsel_i ? man1_i : man0_i;
  assign cur_exp = gsel_i ? exp1_i : exp0_i;
  assign raw_err = $signed({1'b0, thr_i}) - $signed({1'b0, mag_i});
  assign err     = median_i ? (raw_err[ERR_W-1] ? FIX_NEG : FIX_POS) : raw_err;
  assign prod    = $signed({1'b0, cur_man}) * err;
  assign sh      = 5'(SHIFT_BASE) - {1'b0, cur_exp};
  assign step    = SUM_W'(prod) >>> sh;
  assign sum     = SUM_W'(acc_q) + step;
  assign hi_x    = SUM_W'(lim_hi_i);
  assign lo_x    = SUM_W'(lim_lo_i);
  assign nxt     = (sum > hi_x) ? lim_hi_i : (sum < lo_x) ? lim_lo_i : ACC_W'(sum);
  assign clr_any = sync_clr_i | (be_rst_i & ~hold_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          acc_q <= '0;
    else if (clr_any)    acc_q <= '0;
    else if (valid_i)    acc_q <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gain_o <= '0;
    else        gain_o <= acc_q;

  p_sync_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr_i |=> acc_q == '0);
  p_be_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    be_rst_i && !hold_i |=> acc_q == '0);
  p_be_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    be_rst_i && hold_i && !sync_clr_i && !valid_i |=> $stable(acc_q));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i && !clr_any |=> $stable(acc_q));
  p_out_pipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gain_o == $past(acc_q));
  p_zero_man_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !clr_any && cur_man == 4'd0 && acc_q <= lim_hi_i && acc_q >= lim_lo_i
    |=> $stable(acc_q));
  p_limits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !clr_any |=> acc_q <= $past(lim_hi_i) && acc_q >= $past(lim_lo_i));
  p_slew_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !clr_any && acc_q <= lim_hi_i && acc_q >= lim_lo_i
    |=> (acc_q - $past(acc_q) <= MAX_STEP) && ($past(acc_q) - acc_q <= MAX_STEP));
endmodule

// File: tb/tb_agc_loop_filter.sv
`timescale 1ns/1ps
module tb_agc_loop_filter;
  logic clk = 0, rst_n = 0;
  logic valid_i = 0, median_i = 0, gsel_i = 0, hold_i = 0, sync_clr_i = 0, be_rst_i = 0;
  logic [11:0] mag_i = 0, thr_i = 0;
  logic [3:0] man0_i = 0, exp0_i = 0, man1_i = 0, exp1_i = 0;
  logic signed [19:0] lim_hi_i = 20'sd524287, lim_lo_i = -20'sd524288;
  logic signed [19:0] gain_o;
  int checks = 0, fails = 0, mdl = 0;

  always #4 clk = ~clk;

  agc_loop_filter dut (.*);

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int calc_step(input int thr, input int mag);
    int err, m, e;
    err = thr - mag;
    if (median_i) err = (err >= 0) ? 1024 : -1024;
    m = gsel_i ? int'(man1_i) : int'(man0_i);
    e = gsel_i ? int'(exp1_i) : int'(exp0_i);
    return (m * err) >>> (23 - e);
  endfunction

  function automatic int clampv(input int v);
    if (v > int'(lim_hi_i)) return int'(lim_hi_i);
    if (v < int'(lim_lo_i)) return int'(lim_lo_i);
    return v;
  endfunction

  task automatic do_clear();
    @(negedge clk) sync_clr_i = 1;
    @(negedge clk) sync_clr_i = 0;
    @(negedge clk);
    mdl = 0;
  endtask

  task automatic do_sample(input int thr, input int mag);
    @(negedge clk) begin thr_i = 12'(thr); mag_i = 12'(mag); valid_i = 1; end
    mdl = clampv(mdl + calc_step(thr, mag));
    @(negedge clk) valid_i = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int thrs[4] = '{4095, 0, 1000, 300};
    int mags[4] = '{0, 4095, 1000, 1234};
    repeat (3) @(negedge clk);
    chk("R9 reset", int'(gain_o), 0);
    rst_n = 1;

    for (int md = 0; md < 2; md++)
      for (int gs = 0; gs < 2; gs++)
        for (int m = 0; m < 16; m++)
          for (int e = 0; e < 16; e++)
            for (int p = 0; p < 4; p++) begin
              median_i = md[0]; gsel_i = gs[0];
              if (gs == 0) begin man0_i = 4'(m); exp0_i = 4'(e); man1_i = 4'(15-m); exp1_i = 4'(15-e); end
              else begin man1_i = 4'(m); exp1_i = 4'(e); man0_i = 4'(15-m); exp0_i = 4'(15-e); end
              do_clear();
              do_sample(thrs[p], mags[p]);
              if (m == 0) chk("R7 zero mantissa", int'(gain_o), 0);
              else if (md == 1) chk("R1/R2/R4 median step", int'(gain_o), mdl);
              else chk("R1/R2/R3 mean step", int'(gain_o), mdl);
              if (m == 15 && e == 15)
                chk("R10 slew bound", (int'(gain_o) > 240 || int'(gain_o) < -240) ? 1 : 0, 0);
            end

    // R1 worked example: m=5, e=12, err=2048 -> 5
    median_i = 0; gsel_i = 0; man0_i = 4'd5; exp0_i = 4'd12;
    do_clear(); do_sample(2048, 0);
    chk("R1 example gain", int'(gain_o), 5);

    // R8 saturation
    lim_hi_i = 20'sd100; lim_lo_i = -20'sd80;
    man0_i = 4'd15; exp0_i = 4'd15;
    do_clear(); do_sample(4095, 0);
    chk("R8 upper limit", int'(gain_o), 100);
    do_sample(0, 4095);
    chk("R8 lower limit", int'(gain_o), -80);
    lim_hi_i = 20'sd524287; lim_lo_i = -20'sd524288;

    // R9 latency and idle
    do_clear();
    @(negedge clk) begin thr_i = 12'd4095; mag_i = 0; valid_i = 1; end
    @(negedge clk) valid_i = 0;
    chk("R9 not yet visible", int'(gain_o), 0);
    @(negedge clk);
    chk("R9 one cycle later", int'(gain_o), 239);
    mdl = 239;
    gsel_i = 1; thr_i = 0; mag_i = 12'd4095;
    repeat (5) @(negedge clk);
    chk("R9 idle without valid", int'(gain_o), 239);
    gsel_i = 0;

    // R6 backend reset with hold, then without
    hold_i = 1;
    @(negedge clk) be_rst_i = 1;
    @(negedge clk) be_rst_i = 0;
    @(negedge clk);
    chk("R6 hold keeps value", int'(gain_o), 239);
    hold_i = 0;
    @(negedge clk) be_rst_i = 1;
    @(negedge clk) be_rst_i = 0;
    @(negedge clk);
    chk("R6 backend clears", int'(gain_o), 0);

    // R5 sync clear with hold set and valid simultaneously
    do_sample(4095, 0);
    hold_i = 1;
    @(negedge clk) begin sync_clr_i = 1; valid_i = 1; end
    @(negedge clk) begin sync_clr_i = 0; valid_i = 0; end
    @(negedge clk);
    chk("R5 sync clears over valid and hold", int'(gain_o), 0);
    hold_i = 0;

    // R4 median accumulates symmetric steps: m=8,e=15 -> +/-512>>... 
    median_i = 1; man0_i = 4'd8; exp0_i = 4'd15;
    do_clear();
    do_sample(5, 5); do_sample(5, 5); do_sample(3, 9);
    chk("R4 median zero-positive run", int'(gain_o), mdl);
    chk("R4 median net one step", int'(gain_o), 32);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule